// File: doc/BRIEF.md
# Power Domain Corruption Wrapper

This block stands in for one switchable power domain on an emulation model, where X values cannot exist. It holds the domain's bank of state registers and the domain's view of its inputs and outputs. Whenever the domain's power enable drops, the state bank is overwritten with concrete garbage. Four corruption policies are available: a seeded pseudo-random pattern, bitwise inversion, all zeros or all ones. While the domain stays dark, its outputs show a fresh pseudo-random value every cycle. Optionally its inputs do the same, and optionally the state bank is corrupted again at a fixed period.

The random source is a 32-bit LFSR. It is loaded at global reset from a seed input combined with a per-instance constant. A test run can therefore be replayed exactly, and two copies of the same wrapped logic corrupt independently. When power comes back, nothing is reset implicitly. Whatever the domain holds after corruption stays until the domain's own logic writes or resets it while powered. A one-cycle pulse marks every corruption event.

Top module: `pwr_corrupt_wrap`

## Requirements
- R1: While `rst_n` is low, `state_q` is 0 and `corrupt_pulse` is 0. The LFSR loads `seed ^ SALT`, or 32'h1 when that value is zero. The domain counts as powered at reset release.
- R2: The LFSR advances once per cycle after reset as `next = {0, q[31:1]} ^ (q[0] ? 32'h80000057 : 0)`. A random view of width W and offset K takes, at bit i, the XOR of all `q[j]` with `j % W == (i+K) % W` when W is at most 32. The state view uses K=0, the output view K=0 and the input view K=5. With the default widths, this gives state = q, outputs = `q[15:0]^q[31:16]`, and inputs = that fold rotated right by 5.
- R3: The first clock edge that samples `pwr_on` low after it was sampled high corrupts the state bank from the current LFSR value. The result is visible after that edge. With `interval` = 0, no further corruption happens while power stays off.
- R4: `policy` selects the corruption: 0 = LFSR state view, 1 = invert every state bit, 2 = all zeros, 3 = all ones.
- R5: `dom_out` equals `func_out` while `pwr_on` is high. While it is low, `dom_out` equals the output view of the current LFSR value, so it changes every cycle.
- R6: While `pwr_on` is low and `in_corrupt_en` is high, `dom_in` equals the input view of the current LFSR value. Otherwise `dom_in` equals `func_in`.
- R7: With `interval` = N > 0, the state bank is corrupted again every N cycles after the power-off edge for as long as power stays off. The period counter restarts at every power-off edge.
- R8: While power is off, `state_we` and `dom_srst` have no effect on `state_q`.
- R9: Power-up never resets the state bank. While powered, `dom_srst` clears it and `state_we` loads `state_wdata`.
- R10: Instances with different `SALT` values use separate LFSR streams. One instance being off does not disturb another.
- R11: `corrupt_pulse` is high for exactly the cycle after each corrupting edge and never follows an edge at which `pwr_on` was high.
- R12: The same seed gives the same corruption values on every run from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, synchronous |
| seed | input | 32 | LFSR seed, loaded during reset |
| pwr_on | input | 1 | Domain power enable |
| policy | input | 2 | Corruption policy select |
| interval | input | IVL_W | Periodic re-corruption period; 0 disables it |
| in_corrupt_en | input | 1 | Also corrupt domain inputs while off |
| state_we | input | 1 | State bank write enable |
| state_wdata | input | STATE_W | State bank write data |
| dom_srst | input | 1 | Domain synchronous reset |
| func_out | input | OUT_W | Outputs produced by the domain logic |
| func_in | input | IN_W | Inputs arriving at the domain |
| state_q | output | STATE_W | State bank contents |
| dom_out | output | OUT_W | Domain outputs as seen by neighbours |
| dom_in | output | IN_W | Domain inputs as seen by its logic |
| corrupt_pulse | output | 1 | One-cycle marker of each corruption event |

## Verification
Corruption of the state bank and `corrupt_pulse` are due one edge after the stimulus. The bench changes `pwr_on` on a falling edge and reads both on the next falling edge. It takes the expected random value from its own LFSR model as that model stood before the corrupting edge. `dom_out` and `dom_in` are combinational from the current LFSR value. They are compared in the same half cycle against the model's current value. For periodic re-corruption, each falling edge after power-off is checked against a pulse pattern counted from the off edge. Writes and resets applied while the domain is off are read back one edge later through `state_q`.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

   typedef enum logic [1:0] {
      POL_RAND = 2'd0,
      POL_INV  = 2'd1,
      POL_ZERO = 2'd2,
      POL_ONE  = 2'd3
   } pol_e;

   localparam int          LFSR_W    = 32;
   localparam logic [31:0] LFSR_TAPS = 32'h8000_0057;

   function automatic logic [31:0] lfsr_next(input logic [31:0] q);
      return {1'b0, q[31:1]} ^ (q[0] ? LFSR_TAPS : 32'h0);
   endfunction

   function automatic logic [31:0] lfsr_load(input logic [31:0] s,
                                             input logic [31:0] salt);
      logic [31:0] v;
      v = s ^ salt;
      return (v == 32'h0) ? 32'h1 : v;
   endfunction

   // Bit i of a random view of width w and offset k, folded from the LFSR.
   function automatic logic view_bit(input logic [31:0] q, input int i,
                                     input int w, input int k);
      logic b;
      b = 1'b0;
      if (w <= LFSR_W) begin
         for (int j = 0; j < LFSR_W; j++)
            if ((j % w) == ((i + k) % w)) b = b ^ q[j];
      end else begin
         b = q[(i + k) % LFSR_W];
         if (i >= LFSR_W) b = b ^ q[(i + k + 7 * (i / LFSR_W)) % LFSR_W];
      end
      return b;
   endfunction

endpackage

// File: rtl/pcw_lfsr.sv
module pcw_lfsr
   import pcw_pkg::*;
#(
   parameter logic [31:0] SALT = 32'h1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] seed,
   output logic [31:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n) q <= lfsr_load(seed, SALT);
      else        q <= lfsr_next(q);
   end

endmodule

// File: rtl/pcw_rand_view.sv
module pcw_rand_view
   import pcw_pkg::*;
#(
   parameter int W   = 16,
   parameter int OFS = 0
) (
   input  logic [31:0]  lfsr,
   output logic [W-1:0] rnd
);

   for (genvar g = 0; g < W; g++) begin : g_bit
      assign rnd[g] = view_bit(lfsr, g, W, OFS);
   end

endmodule

// File: rtl/pcw_ctrl.sv
module pcw_ctrl #(
   parameter int IVL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_on,
   input  logic [IVL_W-1:0] interval,
   output logic             evt
);

   logic             pwr_q;
   logic [IVL_W-1:0] cnt;
   logic             off_edge;
   logic             stay_off;
   logic             tick;

   assign off_edge = pwr_q & ~pwr_on;
   assign stay_off = ~pwr_q & ~pwr_on;
   assign tick     = stay_off && (interval != '0) &&
                     (cnt >= interval - 1'b1);
   assign evt      = off_edge | tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwr_q <= 1'b1;
         cnt   <= '0;
      end else begin
         pwr_q <= pwr_on;
         if (off_edge || tick)
            cnt <= '0;
         else if (stay_off && (interval != '0))
            cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/pcw_state_bank.sv
module pcw_state_bank
   import pcw_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pwr_on,
   input  logic         evt,
   input  pol_e         policy,
   input  logic [W-1:0] rnd,
   input  logic         we,
   input  logic [W-1:0] wdata,
   input  logic         srst,
   output logic [W-1:0] q
);

   logic [W-1:0] corrupt_val;

   always_comb begin
      unique case (policy)
         POL_RAND: corrupt_val = rnd;
         POL_INV:  corrupt_val = ~q;
         POL_ZERO: corrupt_val = '0;
         default:  corrupt_val = '1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      q <= '0;
      else if (evt)    q <= corrupt_val;
      else if (pwr_on) begin
         if (srst)     q <= '0;
         else if (we)  q <= wdata;
      end
   end

endmodule

// File: rtl/pwr_corrupt_wrap.sv
module pwr_corrupt_wrap
   import pcw_pkg::*;
#(
   parameter int          STATE_W = 32,
   parameter int          OUT_W   = 16,
   parameter int          IN_W    = 16,
   parameter int          IVL_W   = 16,
   parameter logic [31:0] SALT    = 32'h6B8B_4567
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [31:0]        seed,
   input  logic               pwr_on,
   input  logic [1:0]         policy,
   input  logic [IVL_W-1:0]   interval,
   input  logic               in_corrupt_en,
   input  logic               state_we,
   input  logic [STATE_W-1:0] state_wdata,
   input  logic               dom_srst,
   input  logic [OUT_W-1:0]   func_out,
   input  logic [IN_W-1:0]    func_in,
   output logic [STATE_W-1:0] state_q,
   output logic [OUT_W-1:0]   dom_out,
   output logic [IN_W-1:0]    dom_in,
   output logic               corrupt_pulse
);

   localparam int STATE_OFS = 0;
   localparam int OUT_OFS   = 0;
   localparam int IN_OFS    = 5;

   if (STATE_W < 1 || OUT_W < 1 || IN_W < 1) begin : g_bad_width
      $error("pwr_corrupt_wrap: widths must be at least 1");
   end
   if (IVL_W < 1 || IVL_W > 32) begin : g_bad_ivl
      $error("pwr_corrupt_wrap: IVL_W must lie in 1..32");
   end

   logic [31:0]        lfsr_q;
   logic               evt;
   logic [STATE_W-1:0] rnd_state;
   logic [OUT_W-1:0]   rnd_out;
   logic [IN_W-1:0]    rnd_in;

   pcw_lfsr #(.SALT(SALT)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .seed  (seed),
      .q     (lfsr_q)
   );

   pcw_rand_view #(.W(STATE_W), .OFS(STATE_OFS)) u_view_state (
      .lfsr (lfsr_q),
      .rnd  (rnd_state)
   );

   pcw_rand_view #(.W(OUT_W), .OFS(OUT_OFS)) u_view_out (
      .lfsr (lfsr_q),
      .rnd  (rnd_out)
   );

   pcw_rand_view #(.W(IN_W), .OFS(IN_OFS)) u_view_in (
      .lfsr (lfsr_q),
      .rnd  (rnd_in)
   );

   pcw_ctrl #(.IVL_W(IVL_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_on   (pwr_on),
      .interval (interval),
      .evt      (evt)
   );

   pcw_state_bank #(.W(STATE_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .pwr_on (pwr_on),
      .evt    (evt),
      .policy (pol_e'(policy)),
      .rnd    (rnd_state),
      .we     (state_we),
      .wdata  (state_wdata),
      .srst   (dom_srst),
      .q      (state_q)
   );

   assign dom_out = pwr_on ? func_out : rnd_out;
   assign dom_in  = (!pwr_on && in_corrupt_en) ? rnd_in : func_in;

   always_ff @(posedge clk) begin
      if (!rst_n) corrupt_pulse <= 1'b0;
      else        corrupt_pulse <= evt;
   end

endmodule

// File: rtl/pcw_checker.sv
module pcw_checker #(
   parameter int STATE_W = 32,
   parameter int IVL_W   = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pwr_on,
   input logic [1:0]         policy,
   input logic [IVL_W-1:0]   interval,
   input logic [STATE_W-1:0] state_q,
   input logic               corrupt_pulse
);

   logic prev_on;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_on <= 1'b1;
      else        prev_on <= pwr_on;
   end

   a_r3_off_edge_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_on && !pwr_on) |=> corrupt_pulse);

   a_r8_off_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_on) |=> (corrupt_pulse || $stable(state_q)));

   a_r4_zero_policy: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_on && !pwr_on && policy == 2'd2) |=> (state_q == '0));

   a_r4_one_policy: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_on && !pwr_on && policy == 2'd3) |=> (state_q == '1));

   a_r4_inv_policy: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_on && !pwr_on && policy == 2'd1) |=> (state_q == ~$past(state_q)));

   a_r11_no_pulse_powered: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_on |=> !corrupt_pulse);

   a_r7_no_repeat_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!prev_on && !pwr_on && interval == '0) |=> !corrupt_pulse);

endmodule

bind pwr_corrupt_wrap pcw_checker #(.STATE_W(STATE_W), .IVL_W(IVL_W)) u_pcw_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .pwr_on        (pwr_on),
   .policy        (policy),
   .interval      (interval),
   .state_q       (state_q),
   .corrupt_pulse (corrupt_pulse)
);

// File: tb/pwr_corrupt_wrap_bench.sv
module pwr_corrupt_wrap_bench;

   localparam logic [31:0] SALT_A = 32'h5A5A_0001;
   localparam logic [31:0] SALT_B = 32'h0F0F_7777;
   localparam logic [31:0] TAPS   = 32'h8000_0057;
   localparam logic [31:0] S0     = 32'h1357_9BDF;
   localparam logic [31:0] S1     = 32'hACE1_0042;

   // policy, preload
   localparam logic [33:0] VEC [6] = '{
      {2'd0, 32'hDEAD_BEEF},
      {2'd1, 32'h1234_5678},
      {2'd2, 32'hFFFF_0000},
      {2'd3, 32'h0000_00F0},
      {2'd1, 32'h0000_0000},
      {2'd0, 32'hCAFE_0001}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] seed = S0;
   logic        pwr_a = 1'b1, pwr_b = 1'b1;
   logic [1:0]  policy = 2'd0;
   logic [15:0] interval = '0;
   logic        inc_en = 1'b0;
   logic        we_a = 1'b0, we_b = 1'b0, srst = 1'b0;
   logic [31:0] wd_a = '0, wd_b = '0;
   logic [15:0] func_out = '0, func_in = '0;
   logic [31:0] st_a, st_b;
   logic [15:0] out_a, out_b, in_a, in_b;
   logic        pl_a, pl_b;

   int total = 0;
   int bad   = 0;
   logic [31:0] m_a, m_b;

   always #5 clk = ~clk;

   pwr_corrupt_wrap #(.SALT(SALT_A)) u_pwr_corrupt_wrap (
      .clk(clk), .rst_n(rst_n), .seed(seed), .pwr_on(pwr_a), .policy(policy),
      .interval(interval), .in_corrupt_en(inc_en), .state_we(we_a),
      .state_wdata(wd_a), .dom_srst(srst), .func_out(func_out), .func_in(func_in),
      .state_q(st_a), .dom_out(out_a), .dom_in(in_a), .corrupt_pulse(pl_a));

   pwr_corrupt_wrap #(.SALT(SALT_B)) u_pwr_corrupt_wrap_b (
      .clk(clk), .rst_n(rst_n), .seed(seed), .pwr_on(pwr_b), .policy(policy),
      .interval(16'd0), .in_corrupt_en(1'b0), .state_we(we_b),
      .state_wdata(wd_b), .dom_srst(1'b0), .func_out(func_out), .func_in(func_in),
      .state_q(st_b), .dom_out(out_b), .dom_in(in_b), .corrupt_pulse(pl_b));

   function automatic logic [31:0] nxt(input logic [31:0] q);
      return {1'b0, q[31:1]} ^ (q[0] ? TAPS : 32'h0);
   endfunction

   function automatic logic [31:0] ld(input logic [31:0] s, input logic [31:0] salt);
      return ((s ^ salt) == 32'h0) ? 32'h1 : (s ^ salt);
   endfunction

   function automatic logic [15:0] fold(input logic [31:0] q);
      return q[15:0] ^ q[31:16];
   endfunction

   function automatic logic [15:0] in_view(input logic [31:0] q);
      logic [15:0] f;
      f = fold(q);
      return {f[4:0], f[15:5]};
   endfunction

   // Reference LFSR streams, from the R1/R2 definitions
   always @(posedge clk) begin
      if (!rst_n) begin
         m_a <= ld(seed, SALT_A);
         m_b <= ld(seed, SALT_B);
      end else begin
         m_a <= nxt(m_a);
         m_b <= nxt(m_b);
      end
   end

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [31:0] s);
      @(negedge clk);
      rst_n = 1'b0; seed = s; pwr_a = 1'b1; pwr_b = 1'b1;
      interval = '0; inc_en = 1'b0; we_a = 1'b0; we_b = 1'b0; srst = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] exp_v, r1, r2;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(st_a == 32'h0, "R1 state in reset", st_a, 32'h0);
      chk(pl_a == 1'b0, "R1 pulse in reset", {31'h0, pl_a}, 32'h0);

      // R1: seed equal to salt loads 1; first edge after release corrupts
      do_reset(SALT_A);
      pwr_a = 1'b0; policy = 2'd0;
      @(negedge clk);
      chk(st_a == 32'h1, "R1 zero seed substitute", st_a, 32'h1);
      chk(pl_a == 1'b1, "R11 pulse at first off edge", {31'h0, pl_a}, 32'h1);

      do_reset(S0);

      // Vector table: R3, R4, R8, R9, R10, R11
      for (int v = 0; v < 6; v++) begin
         logic [1:0]  pol;
         logic [31:0] pre;
         pol = VEC[v][33:32];
         pre = VEC[v][31:0];
         @(negedge clk);
         pwr_a = 1'b1; we_a = 1'b1; wd_a = pre; we_b = 1'b1; wd_b = ~pre;
         policy = pol; interval = '0;
         @(negedge clk);
         we_a = 1'b0; we_b = 1'b0;
         chk(st_a == pre, "R9 powered write", st_a, pre);
         pwr_a = 1'b0;
         case (pol)
            2'd0:    exp_v = m_a;
            2'd1:    exp_v = ~pre;
            2'd2:    exp_v = 32'h0;
            default: exp_v = 32'hFFFF_FFFF;
         endcase
         @(negedge clk);
         chk(st_a == exp_v, "R4 policy result at off edge (R3)", st_a, exp_v);
         chk(pl_a == 1'b1, "R11 pulse on corruption", {31'h0, pl_a}, 32'h1);
         chk(st_b == ~pre, "R10 other instance undisturbed", st_b, ~pre);
         chk(out_a == fold(m_a), "R5 random outputs while off",
             {16'h0, out_a}, {16'h0, fold(m_a)});
         we_a = 1'b1; wd_a = 32'h5555_5555; srst = 1'b1;
         @(negedge clk);
         chk(pl_a == 1'b0, "R3 single corruption", {31'h0, pl_a}, 32'h0);
         chk(st_a == exp_v, "R8 write and srst ignored while off", st_a, exp_v);
         we_a = 1'b0; srst = 1'b0; pwr_a = 1'b1;
         @(negedge clk);
         chk(st_a == exp_v, "R9 no implicit reset at power-up", st_a, exp_v);
         chk(pl_a == 1'b0, "R11 no pulse at power-up", {31'h0, pl_a}, 32'h0);
      end

      // R9: domain synchronous reset while powered
      @(negedge clk);
      srst = 1'b1;
      @(negedge clk);
      srst = 1'b0;
      chk(st_a == 32'h0, "R9 srst while powered", st_a, 32'h0);

      // R5 / R6: output and input views
      func_out = 16'hA5C3; func_in = 16'h3C5A; inc_en = 1'b1;
      @(negedge clk);
      chk(out_a == 16'hA5C3, "R5 outputs pass while on", {16'h0, out_a}, 32'h0000_A5C3);
      chk(in_a == 16'h3C5A, "R6 inputs pass while on", {16'h0, in_a}, 32'h0000_3C5A);
      pwr_a = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(out_a == fold(m_a), "R5 outputs refresh each cycle",
             {16'h0, out_a}, {16'h0, fold(m_a)});
         chk(in_a == in_view(m_a), "R6 inputs corrupted while off",
             {16'h0, in_a}, {16'h0, in_view(m_a)});
      end
      inc_en = 1'b0;
      @(negedge clk);
      chk(in_a == 16'h3C5A, "R6 inputs pass when disabled", {16'h0, in_a}, 32'h0000_3C5A);
      // R3: interval 0 gives no repeat over several off cycles
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(pl_a == 1'b0, "R3 no repeat with interval 0", {31'h0, pl_a}, 32'h0);
      end

      // R7: periodic re-corruption, invert policy, period 3
      pwr_a = 1'b1; we_a = 1'b1; wd_a = 32'h0F0F_3C3C; policy = 2'd1; interval = 16'd3;
      @(negedge clk);
      we_a = 1'b0;
      pwr_a = 1'b0;
      for (int k = 1; k <= 7; k++) begin
         logic ep;
         logic [31:0] es;
         @(negedge clk);
         ep = (k == 1 || k == 4 || k == 7);
         es = (k >= 4 && k <= 6) ? 32'h0F0F_3C3C : ~32'h0F0F_3C3C;
         chk(pl_a == ep, "R7 periodic pulse pattern", {31'h0, pl_a}, {31'h0, ep});
         chk(st_a == es, "R7 periodic state", st_a, es);
      end
      pwr_a = 1'b1; interval = '0;

      // R10: both instances off on the same edge, random policy
      @(negedge clk);
      policy = 2'd0; pwr_a = 1'b0; pwr_b = 1'b0;
      r1 = m_a; r2 = m_b;
      @(negedge clk);
      chk(st_a == r1, "R10 instance A stream", st_a, r1);
      chk(st_b == r2, "R10 instance B stream", st_b, r2);
      chk(st_a != st_b, "R10 streams differ", st_a, ~st_b);
      pwr_a = 1'b1; pwr_b = 1'b1;

      // R12: same seed reproduces the same corruption
      do_reset(S1);
      repeat (4) @(negedge clk);
      pwr_a = 1'b0; policy = 2'd0; exp_v = m_a;
      @(negedge clk);
      r1 = st_a;
      chk(r1 == exp_v, "R12 first run matches model", r1, exp_v);
      do_reset(S1);
      repeat (4) @(negedge clk);
      pwr_a = 1'b0; policy = 2'd0;
      @(negedge clk);
      r2 = st_a;
      chk(r2 == r1, "R12 replay identical", r2, r1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule